// File: doc/BRIEF.md
# Auto-Ranging Frequency and Period Counter

This block measures how fast a digital input toggles, using its own clock as the time reference. It starts in a gated mode: it opens a window of a fixed number of reference cycles and counts the input's rising edges inside it. With a window of one second the count is the frequency in hertz. Gated counting carries an uncertainty of one edge, which hurts only at low rates. So when a gated count comes out under a programmable threshold, the next measurement switches to period mode. In period mode the block counts reference cycles across several whole input periods. When a period result shows that the rate is back at or above the threshold, the block returns to gated mode.

Each result comes out as a raw count with two flags: the mode that produced it, and whether the input went silent. The flags and the count arrive with a one-cycle strobe. A single-shot pulse starts one measurement. A level input chains measurements back to back. Converting periods into frequencies is left to the consumer.

Top module: `freq_autorange_counter`

## Requirements
- R1: After reset, `valid_o`, `result_o`, `mode_o` and `nosig_o` are all zero, and the first measurement after reset is gated.
- R2: A gated measurement lasts exactly GATE_CYCLES reference cycles. `result_o` is the number of input rising edges detected in that window, with `mode_o`=0 and `nosig_o`=0.
- R3: If a gated count is below THRESH_COUNT, the next measurement is a period measurement. Otherwise the next measurement is gated again.
- R4: A period measurement arms on an input rising edge. `result_o` is the number of reference cycles from that edge to the N_AVG-th following rising edge, reported with `mode_o`=1 and `nosig_o`=0.
- R5: A period result that is at most N_AVG*GATE_CYCLES/THRESH_COUNT (integer division) makes the next measurement gated. A larger result keeps the next measurement in period mode.
- R6: In period mode, TIMEOUT_CYCLES consecutive reference cycles without an input rising edge end the measurement. The report has `nosig_o`=1, `mode_o`=1 and `result_o`=0, and the next measurement is gated.
- R7: A `start_i` pulse while idle launches exactly one measurement. `cont_i` high chains each new measurement onto the cycle after the previous one ends. `start_i` pulses during a measurement have no effect. With `cont_i` low when a measurement ends, the block goes idle.
- R8: `valid_o` is high for exactly one cycle with each result. `result_o`, `mode_o` and `nosig_o` change only together with `valid_o` and hold between strobes.
- R9: `sig_i` passes through a two-stage synchronizer. An input rising edge first seen at clock edge k counts as a rising edge in the cycle that ends at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Asynchronous signal under measurement |
| start_i | input | 1 | Single-shot launch pulse, taken only when idle |
| cont_i | input | 1 | Continuous run: chains measurements while high |
| result_o | output | 32 | Edge count (gated) or reference-cycle count (period) |
| mode_o | output | 1 | 0 = gated result, 1 = period result |
| nosig_o | output | 1 | Period-mode timeout: input stalled |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The synchronizer and edge detector put three register stages between an input change and the edge count. The final measurement decision is registered once more into the outputs. As a result, `valid_o` rises one cycle after the gate's last cycle, after the closing period edge, or after the last silent cycle. The bench's behavioural reference model advances on every clock edge using the same sampled input. It produces the expected strobe and output values for that exact cycle, and it compares them with the ports at the falling edge, half a cycle after they settle. Scenario checks then wait for strobes. Using the known input period, they confirm counts, mode switching, timeouts and the launch rules, and they allow for measurements that straddle a change of input rate.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int AFC_CNT_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_ARM  = 2'd2,
        ST_PER  = 2'd3
    } afc_state_e;

    typedef struct packed {
        logic                 period;
        logic                 nosig;
        logic [AFC_CNT_W-1:0] count;
    } afc_result_t;

    // Gated count too small for one-edge resolution to be acceptable
    function automatic logic gate_needs_period(input logic [AFC_CNT_W-1:0] cnt,
                                               input logic [AFC_CNT_W-1:0] thresh);
        return cnt < thresh;
    endfunction

    // Period total still longer than the threshold rate allows
    function automatic logic period_stays(input logic [AFC_CNT_W-1:0] total,
                                          input logic [AFC_CNT_W-1:0] limit);
        return total > limit;
    endfunction

endpackage

// File: rtl/afc_edge_sync.sv
module afc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_async,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], sig_async};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/afc_sequencer.sv
module afc_sequencer
    import afc_pkg::*;
#(
    parameter int GATE_CYCLES    = 50_000_000,
    parameter int THRESH_COUNT   = 150_000,
    parameter int N_AVG          = 4,
    parameter int TIMEOUT_CYCLES = 100_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  logic        start,
    input  logic        cont,
    output logic        done,
    output afc_result_t res,
    output afc_state_e  state
);
    localparam int CW        = AFC_CNT_W;
    localparam int PER_LIMIT = (N_AVG * GATE_CYCLES) / THRESH_COUNT;

    afc_state_e    state_q, state_d;
    logic          want_q, want_d;
    logic [CW-1:0] tick_q, tick_d, gap_q, gap_d, ecnt_q, ecnt_d;
    logic          launch, launch_per, timed_out;

    assign state = state_q;

    always_comb begin
        state_d    = state_q;
        want_d     = want_q;
        tick_d     = tick_q;
        gap_d      = gap_q;
        ecnt_d     = ecnt_q;
        done       = 1'b0;
        res        = '0;
        launch     = 1'b0;
        launch_per = want_q;
        timed_out  = 1'b0;

        case (state_q)
            ST_IDLE: begin
                launch = start | cont;
            end
            ST_GATE: begin
                tick_d = tick_q + 1'b1;
                ecnt_d = ecnt_q + CW'(rise);
                if (tick_q == CW'(GATE_CYCLES - 1)) begin
                    done       = 1'b1;
                    res.count  = ecnt_d;
                    want_d     = gate_needs_period(ecnt_d, CW'(THRESH_COUNT));
                end
            end
            ST_ARM: begin
                gap_d = gap_q + 1'b1;
                if (rise) begin
                    state_d = ST_PER;
                    tick_d  = '0;
                    gap_d   = '0;
                    ecnt_d  = '0;
                end else if (gap_q == CW'(TIMEOUT_CYCLES - 1)) begin
                    timed_out = 1'b1;
                end
            end
            default: begin
                tick_d = tick_q + 1'b1;
                if (rise) begin
                    gap_d  = '0;
                    ecnt_d = ecnt_q + 1'b1;
                    if (ecnt_q == CW'(N_AVG - 1)) begin
                        done       = 1'b1;
                        res.period = 1'b1;
                        res.count  = tick_d;
                        want_d     = period_stays(tick_d, CW'(PER_LIMIT));
                    end
                end else begin
                    gap_d = gap_q + 1'b1;
                    if (gap_q == CW'(TIMEOUT_CYCLES - 1)) timed_out = 1'b1;
                end
            end
        endcase

        if (timed_out) begin
            done       = 1'b1;
            res.period = 1'b1;
            res.nosig  = 1'b1;
            res.count  = '0;
            want_d     = 1'b0;
        end

        if (done) begin
            launch     = cont;
            launch_per = want_d;
            state_d    = ST_IDLE;
        end

        if (launch) begin
            state_d = launch_per ? ST_ARM : ST_GATE;
            tick_d  = '0;
            gap_d   = '0;
            ecnt_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            want_q  <= 1'b0;
            tick_q  <= '0;
            gap_q   <= '0;
            ecnt_q  <= '0;
        end else begin
            state_q <= state_d;
            want_q  <= want_d;
            tick_q  <= tick_d;
            gap_q   <= gap_d;
            ecnt_q  <= ecnt_d;
        end
    end
endmodule

// File: rtl/afc_result_hold.sv
module afc_result_hold
    import afc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  afc_result_t          res,
    output logic [AFC_CNT_W-1:0] result_o,
    output logic                 mode_o,
    output logic                 nosig_o,
    output logic                 valid_o
);
    afc_result_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) held_q <= res;
        end
    end

    assign result_o = held_q.count;
    assign mode_o   = held_q.period;
    assign nosig_o  = held_q.nosig;
endmodule

// File: rtl/freq_autorange_counter.sv
module freq_autorange_counter
    import afc_pkg::*;
#(
    parameter int GATE_CYCLES    = 50_000_000,
    parameter int THRESH_COUNT   = 150_000,
    parameter int N_AVG          = 4,
    parameter int TIMEOUT_CYCLES = 100_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sig_i,
    input  logic                 start_i,
    input  logic                 cont_i,
    output logic [AFC_CNT_W-1:0] result_o,
    output logic                 mode_o,
    output logic                 nosig_o,
    output logic                 valid_o
);
    logic        edge_rise;
    logic        seq_done;
    afc_result_t seq_res;
    afc_state_e  seq_state;

    afc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sig_async(sig_i),
        .rise     (edge_rise)
    );

    afc_sequencer #(
        .GATE_CYCLES   (GATE_CYCLES),
        .THRESH_COUNT  (THRESH_COUNT),
        .N_AVG         (N_AVG),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .rise (edge_rise),
        .start(start_i),
        .cont (cont_i),
        .done (seq_done),
        .res  (seq_res),
        .state(seq_state)
    );

    afc_result_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .done    (seq_done),
        .res     (seq_res),
        .result_o(result_o),
        .mode_o  (mode_o),
        .nosig_o (nosig_o),
        .valid_o (valid_o)
    );
endmodule

// File: rtl/afc_checker.sv
module afc_checker
    import afc_pkg::*;
#(
    parameter int GATE_CYCLES = 50_000_000,
    parameter int N_AVG       = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [AFC_CNT_W-1:0] result_o,
    input logic                 mode_o,
    input logic                 nosig_o,
    input logic                 valid_o,
    input logic                 seq_done,
    input afc_state_e           seq_state
);
    // R8: strobe lasts one cycle
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R8: outputs hold between strobes
    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(result_o) && $stable(mode_o) && $stable(nosig_o)));

    // R6: timeout report shape
    assert_nosig_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && nosig_o) |-> (mode_o && result_o == '0));

    // R2: a gated window cannot hold more edges than half its cycles, rounded up
    assert_gate_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !mode_o) |-> (result_o <= AFC_CNT_W'((GATE_CYCLES + 1) / 2)));

    // R4: every averaged period spans at least two reference cycles
    assert_period_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_o && !nosig_o) |-> (result_o >= AFC_CNT_W'(2 * N_AVG)));

    // R7: an idle sequencer reports nothing, and the strobe follows a completion
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_IDLE) |-> !seq_done);

    assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> valid_o);
endmodule

bind freq_autorange_counter afc_checker #(
    .GATE_CYCLES(GATE_CYCLES),
    .N_AVG      (N_AVG)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .result_o (result_o),
    .mode_o   (mode_o),
    .nosig_o  (nosig_o),
    .valid_o  (valid_o),
    .seq_done (seq_done),
    .seq_state(seq_state)
);

// File: tb/freq_autorange_counter_tb_top.sv
`timescale 1ns/1ps
module freq_autorange_counter_tb_top;
    localparam int G   = 200;
    localparam int TH  = 20;
    localparam int NA  = 4;
    localparam int TO  = 300;
    localparam int LIM = (NA * G) / TH;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sig_i = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [31:0] result_o;
    logic        mode_o, nosig_o, valid_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    freq_autorange_counter #(
        .GATE_CYCLES(G), .THRESH_COUNT(TH), .N_AVG(NA), .TIMEOUT_CYCLES(TO)
    ) dut_i (
        .clk(clk), .rst(rst), .sig_i(sig_i), .start_i(start_i), .cont_i(cont_i),
        .result_o(result_o), .mode_o(mode_o), .nosig_o(nosig_o), .valid_o(valid_o)
    );

    // Input generator: period gen_per cycles (0 = held low), high for gen_hi cycles
    int gen_per = 0;
    int gen_hi  = 0;
    int gen_ph  = 0;
    always @(negedge clk) begin
        if (gen_per == 0) begin
            sig_i  <= 1'b0;
            gen_ph <= 0;
        end else begin
            sig_i  <= (gen_ph < gen_hi);
            gen_ph <= (gen_ph + 1 >= gen_per) ? 0 : gen_ph + 1;
        end
    end

    // Behavioural reference model, one step per clock edge
    int  m_st = 0;     // 0 idle, 1 gate, 2 arm, 3 period
    bit  m_want = 0;
    int  m_tick = 0, m_gap = 0, m_ecnt = 0;
    bit  m_s1 = 0, m_s2 = 0, m_pv = 0;
    bit  e_valid = 0, e_mode = 0, e_nos = 0;
    int  e_res = 0;

    always @(posedge clk) begin
        bit rise, fin, go, go_per;
        int r_cnt;
        bit r_mode, r_nos;
        if (rst) begin
            m_st = 0; m_want = 0; m_tick = 0; m_gap = 0; m_ecnt = 0;
            m_s1 = 0; m_s2 = 0; m_pv = 0;
            e_valid = 0; e_mode = 0; e_nos = 0; e_res = 0;
        end else begin
            rise = m_s2 && !m_pv;
            fin = 0; go = 0; go_per = m_want;
            r_cnt = 0; r_mode = 0; r_nos = 0;
            if (m_st == 0) begin
                go = start_i || cont_i;
            end else if (m_st == 1) begin
                if (rise) m_ecnt++;
                if (m_tick == G - 1) begin
                    fin = 1; r_cnt = m_ecnt; m_want = (m_ecnt < TH);
                end
                m_tick++;
            end else if (m_st == 2) begin
                if (rise) begin
                    m_st = 3; m_tick = 0; m_gap = 0; m_ecnt = 0;
                end else if (m_gap == TO - 1) begin
                    fin = 1; r_mode = 1; r_nos = 1; m_want = 0;
                end else m_gap++;
            end else begin
                m_tick++;
                if (rise) begin
                    m_gap = 0; m_ecnt++;
                    if (m_ecnt == NA) begin
                        fin = 1; r_mode = 1; r_cnt = m_tick; m_want = (m_tick > LIM);
                    end
                end else if (m_gap == TO - 1) begin
                    fin = 1; r_mode = 1; r_nos = 1; m_want = 0;
                end else m_gap++;
            end
            e_valid = fin;
            if (fin) begin
                e_res = r_cnt; e_mode = r_mode; e_nos = r_nos;
                go = cont_i; go_per = m_want; m_st = 0;
            end
            if (go) begin
                m_st = go_per ? 2 : 1; m_tick = 0; m_gap = 0; m_ecnt = 0;
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = sig_i;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            checks++;
            if (valid_o !== e_valid || result_o !== 32'(e_res) ||
                mode_o !== e_mode || nosig_o !== e_nos) begin
                fails++;
                $display("FAIL %s cyc %0d: got v=%0b r=%0d m=%0b n=%0b exp v=%0b r=%0d m=%0b n=%0b",
                    (valid_o !== e_valid) ? "R8/R9" : (mode_o !== e_mode) ? "R3/R5" :
                    e_nos ? "R6" : e_mode ? "R4" : "R2",
                    cyc, valid_o, result_o, mode_o, nosig_o, e_valid, e_res, e_mode, e_nos);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int r, output bit m, output bit n);
        do @(negedge clk); while (!valid_o);
        r = int'(result_o); m = mode_o; n = nosig_o;
    endtask

    task automatic set_period(input int p);
        gen_per = p; gen_hi = p / 2;
    endtask

    function automatic bit near(input int a, input int b);
        return (a >= b - 1) && (a <= b + 1);
    endfunction

    task automatic finish_run();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done_flag) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    initial begin
        int r, pr, nv;
        bit m, n, pm, pn, found;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(valid_o == 0 && result_o == 0 && mode_o == 0 && nosig_o == 0, "R1 reset outputs",
              int'(result_o) + valid_o + mode_o + nosig_o, 0);
        rst = 1'b0;
        set_period(5);
        cont_i = 1'b1;
        wait_valid(r, m, n);
        check(m == 0, "R1 first measurement gated", m, 0);
        check(near(r, G / 5) && !n, "R2 gated count P=5", r, G / 5);
        wait_valid(r, m, n);
        check(m == 0 && near(r, G / 5), "R3 count above threshold stays gated", r, G / 5);

        // Drop rate: gated count falls under threshold, then period mode
        set_period(25);
        found = 0; pm = 0; pr = 0;
        for (int i = 0; i < 6 && !found; i++) begin
            wait_valid(r, m, n);
            if (m && !n) begin
                found = 1;
                check(pm == 0 && pr < TH, "R3 period follows low gated count", pr, TH - 1);
                check(r == NA * 25, "R4 period total P=25", r, NA * 25);
            end
            pm = m; pr = r;
        end
        check(found, "R3 period mode reached", found, 1);
        wait_valid(r, m, n);
        check(m == 1 && r == NA * 25, "R5 long period stays in period mode", r, NA * 25);

        // Raise rate to just above threshold: period result at or below limit
        set_period(8);
        found = 0;
        for (int i = 0; i < 6 && !found; i++) begin
            wait_valid(r, m, n);
            if (m && !n && r <= LIM) begin
                found = 1;
                check(r == NA * 8, "R4 period total P=8", r, NA * 8);
                wait_valid(r, m, n);
                check(m == 0 && near(r, G / 8), "R5 short period returns to gated", r, G / 8);
            end
        end
        check(found, "R5 short period seen", found, 1);

        // Stall input while in period mode
        set_period(25);
        found = 0;
        for (int i = 0; i < 6 && !found; i++) begin
            wait_valid(r, m, n);
            if (m && !n) found = 1;
        end
        set_period(0);
        found = 0;
        for (int i = 0; i < 6 && !found; i++) begin
            wait_valid(r, m, n);
            if (n) begin
                found = 1;
                check(m == 1 && r == 0, "R6 timeout report", r, 0);
                wait_valid(r, pm, pn);
                check(pm == 0 && !pn && r == 0, "R6 next measurement gated", pm, 0);
            end
        end
        check(found, "R6 timeout seen", found, 1);

        // Stop continuous running: block goes idle
        cont_i = 1'b0;
        wait_valid(r, m, n);
        nv = 0;
        for (int i = 0; i < 2 * G + 2 * TO; i++) begin
            @(negedge clk);
            if (valid_o) nv++;
        end
        check(nv == 0, "R7 idle after cont low", nv, 0);

        // Single shot, with a second start while busy ignored
        set_period(5);
        repeat (20) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        nv = 0;
        for (int i = 0; i < 2 * G + 2 * TO; i++) begin
            @(negedge clk);
            if (valid_o) nv++;
        end
        check(nv == 1, "R7 one result per start", nv, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule